// File: doc/BRIEF.md
# Asynchronous External Memory Bus Master

This block connects an internal requester to a 16-bit asynchronous, SRAM-style external bus. The requester offers one read or write at a time with a valid/ready handshake. The block runs the access on the pins in three timed phases: address setup, strobe and hold. It then returns a one-cycle response that carries the read data and an error flag. After each access the block holds the bus idle for a programmable turnaround gap before it accepts the next request.

Every phase length is a configuration field that holds the wanted cycle count minus one. Reads and writes have separate fields. The fields differ in width: 4 bits for setup, 6 bits for strobe, 3 bits for hold and 2 bits for turnaround. An optional wait input can stretch the strobe phase for slow external devices. Its active level is selectable. A maximum wait count bounds the stretch, and an access that reaches the bound ends with an error and sets a sticky timeout flag. The data bus appears as separate input, output and output-enable signals. All strobes are active low.

Configuration inputs must be held steady while an access is in flight.

Top module: `xbus_async_master`

## Requirements
- R1: After reset, bus_cs_n, bus_oe_n and bus_we_n are 1, bus_dq_oe is 0, req_ready is 1, rsp_valid is 0 and tmo_flag is 0.
- R2: A read holds bus_cs_n low for (cfg_rd_setup+1)+(cfg_rd_strobe+1)+(cfg_rd_hold+1)+E cycles, where E is the wait extension. It holds bus_oe_n low for (cfg_rd_strobe+1)+E cycles, and bus_we_n stays 1.
- R3: A write holds bus_cs_n low for (cfg_wr_setup+1)+(cfg_wr_strobe+1)+(cfg_wr_hold+1)+E cycles and bus_we_n low for (cfg_wr_strobe+1)+E cycles. bus_dq_oe is 1 with bus_dout equal to the request data for every cycle that bus_cs_n is low, and bus_oe_n stays 1.
- R4: Read data is taken from bus_din in the last strobe cycle. It is returned on rsp_rdata with rsp_valid, which is high for exactly one cycle: the last hold cycle.
- R5: When a request is already waiting, bus_cs_n stays high for exactly cfg_turn+2 cycles between two accesses.
- R6: With cfg_wait_en=1, a bus_wait level equal to cfg_wait_pol is active. Each cycle that bus_wait is active at the point where strobe would end adds one strobe cycle. This holds for both polarities.
- R7: With cfg_wait_en=0, bus_wait has no effect on any phase length.
- R8: The strobe is extended by at most cfg_wait_max cycles. If bus_wait is still active after that many, the strobe ends anyway, rsp_err is 1 with that response, and tmo_flag goes to 1 and stays 1 until reset. A later access that completes normally returns rsp_err=0.
- R9: An access is atomic. req_ready is 0 from the accepting edge until the turnaround ends, and bus_addr stays stable while bus_cs_n is low.
- R10: bus_oe_n and bus_we_n are never low together, and neither is low while bus_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_setup | input | 4 | Read setup cycles minus one |
| cfg_rd_strobe | input | 6 | Read strobe cycles minus one |
| cfg_rd_hold | input | 3 | Read hold cycles minus one |
| cfg_wr_setup | input | 4 | Write setup cycles minus one |
| cfg_wr_strobe | input | 6 | Write strobe cycles minus one |
| cfg_wr_hold | input | 3 | Write hold cycles minus one |
| cfg_turn | input | 2 | Turnaround idle cycles minus one |
| cfg_wait_en | input | 1 | Enable strobe extension by bus_wait |
| cfg_wait_pol | input | 1 | Active level of bus_wait |
| cfg_wait_max | input | 8 | Maximum extension cycles |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted at this edge when valid |
| rsp_valid | output | 1 | Access complete (one cycle) |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Access ended by wait timeout |
| tmo_flag | output | 1 | Sticky timeout indicator |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_addr | output | 20 | External address |
| bus_dout | output | 16 | Data driven toward the bus |
| bus_dq_oe | output | 1 | Data bus drive enable |
| bus_din | input | 16 | Data read from the bus |
| bus_wait | input | 1 | External wait request |

## Verification
The hardest case to reach is the wait window that runs out exactly at its bound. Here bus_wait must still be active in the strobe cycle where the extension counter equals cfg_wait_max, and it must come after an earlier access of the same setup that stayed just inside the bound. The bench's bus model counts strobe cycles and holds bus_wait active for a chosen number of them. It then sweeps that number below, at and past strobe length plus cfg_wait_max under both polarities. Each access is followed by a plain access that shows the sticky flag persists while the per-access error clears.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TURN
  } xbus_phase_e;

  // A stored field value N stands for N+1 clock cycles.
  function automatic int unsigned field_cycles(input int unsigned fld);
    return fld + 1;
  endfunction

  // The wait pin is active when its level matches the chosen polarity.
  function automatic logic wait_active(input logic lvl, input logic pol);
    return (lvl == pol);
  endfunction

  // Chip-select window of an access: setup + strobe + extension + hold.
  function automatic int unsigned window_cycles(input int unsigned su,
                                                input int unsigned st,
                                                input int unsigned ho,
                                                input int unsigned ext);
    return field_cycles(su) + field_cycles(st) + field_cycles(ho) + ext;
  endfunction

endpackage

// File: rtl/xbus_wait_unit.sv
module xbus_wait_unit #(
  parameter int WCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_last,
  input  logic              wait_en,
  input  logic              wait_pol,
  input  logic              wait_in,
  input  logic [WCNT_W-1:0] wait_max,
  output logic              stall,
  output logic              expire
);
  import xbus_pkg::*;

  logic [WCNT_W-1:0] wcnt;
  logic              act;
  logic              at_limit;

  assign act      = wait_en && wait_active(wait_in, wait_pol);
  assign at_limit = (wcnt == wait_max);
  assign stall    = strobe_last && act && !at_limit;
  assign expire   = strobe_last && act && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wcnt <= '0;
    else if (!strobe_last) wcnt <= '0;
    else if (stall)        wcnt <= wcnt + 1'b1;
  end

  // R8: the extension counter never passes the programmed bound
  p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_last |-> (wcnt <= wait_max));

  // R7: with extension disabled the strobe is never stretched
  p_wait_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_en |-> (!stall && !expire));

  // R8: a stall and a timeout never occur in the same cycle
  p_stall_xor_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && expire));

endmodule

// File: rtl/xbus_phase_seq.sv
module xbus_phase_seq #(
  parameter int CNT_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CNT_W-1:0]     setup_len,
  input  logic [CNT_W-1:0]     strobe_len,
  input  logic [CNT_W-1:0]     hold_len,
  input  logic [CNT_W-1:0]     turn_len,
  input  logic                 stall,
  output xbus_pkg::xbus_phase_e phase,
  output logic                 strobe_last,
  output logic                 strobe_end,
  output logic                 hold_last,
  output logic                 idle
);
  import xbus_pkg::*;

  xbus_phase_e     ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero    = (cnt_q == '0);
  assign phase       = ph_q;
  assign idle        = (ph_q == PH_IDLE);
  assign strobe_last = (ph_q == PH_STROBE) && cnt_zero;
  assign strobe_end  = strobe_last && !stall;
  assign hold_last   = (ph_q == PH_HOLD) && cnt_zero;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_zero ? cnt_q : cnt_q - 1'b1;
    unique case (ph_q)
      PH_IDLE: begin
        cnt_d = cnt_q;
        if (start) begin
          ph_d  = PH_SETUP;
          cnt_d = setup_len;
        end
      end
      PH_SETUP: if (cnt_zero) begin
        ph_d  = PH_STROBE;
        cnt_d = strobe_len;
      end
      PH_STROBE: if (strobe_end) begin
        ph_d  = PH_HOLD;
        cnt_d = hold_len;
      end
      PH_HOLD: if (cnt_zero) begin
        ph_d  = PH_TURN;
        cnt_d = turn_len;
      end
      PH_TURN: if (cnt_zero) ph_d = PH_IDLE;
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  // R9: once started, setup only moves on to strobe
  p_setup_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SETUP) |=> (ph_q == PH_SETUP || ph_q == PH_STROBE));

  // R9: hold is always followed by turnaround, never directly by a new access
  p_hold_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HOLD) |=> (ph_q == PH_HOLD || ph_q == PH_TURN));

  // R9: leaving idle only happens through a start
  p_start_only_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start) |=> (ph_q == PH_IDLE));

endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              strobe_end,
  input  logic              expire,
  input  logic [DATA_W-1:0] bus_din,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              acc_err,
  output logic              tmo_sticky
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_wr    <= 1'b0;
      acc_addr  <= '0;
      acc_wdata <= '0;
    end else if (start) begin
      acc_wr    <= req_write;
      acc_addr  <= req_addr;
      acc_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rdata <= '0;
    else if (strobe_end && !acc_wr) rdata <= bus_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_err <= 1'b0;
    else if (start)      acc_err <= 1'b0;
    else if (strobe_end) acc_err <= expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo_sticky <= 1'b0;
    else if (expire) tmo_sticky <= 1'b1;
  end

  // R8: the timeout indicator only ever rises
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_sticky |=> tmo_sticky);

endmodule

// File: rtl/xbus_async_master.sv
module xbus_async_master #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int SETUP_W  = 4,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 3,
  parameter int TURN_W   = 2,
  parameter int WCNT_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SETUP_W-1:0]  cfg_rd_setup,
  input  logic [STROBE_W-1:0] cfg_rd_strobe,
  input  logic [HOLD_W-1:0]   cfg_rd_hold,
  input  logic [SETUP_W-1:0]  cfg_wr_setup,
  input  logic [STROBE_W-1:0] cfg_wr_strobe,
  input  logic [HOLD_W-1:0]   cfg_wr_hold,
  input  logic [TURN_W-1:0]   cfg_turn,
  input  logic                cfg_wait_en,
  input  logic                cfg_wait_pol,
  input  logic [WCNT_W-1:0]   cfg_wait_max,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  output logic                tmo_flag,
  output logic                bus_cs_n,
  output logic                bus_oe_n,
  output logic                bus_we_n,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_dout,
  output logic                bus_dq_oe,
  input  logic [DATA_W-1:0]   bus_din,
  input  logic                bus_wait
);
  import xbus_pkg::*;

  localparam int W_A   = (SETUP_W > STROBE_W) ? SETUP_W : STROBE_W;
  localparam int W_B   = (HOLD_W > TURN_W) ? HOLD_W : TURN_W;
  localparam int CNT_W = (W_A > W_B) ? W_A : W_B;

  xbus_phase_e      phase;
  logic             start, idle, sel_wr;
  logic             strobe_last, strobe_end, hold_last;
  logic             stall, expire;
  logic             acc_wr, acc_err;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic [CNT_W-1:0] setup_len, strobe_len, hold_len, turn_len;
  logic             in_window, in_strobe;

  assign start  = idle && req_valid;
  assign sel_wr = idle ? req_write : acc_wr;

  // Field selection, zero-extended to the shared counter width
  assign setup_len  = sel_wr ? CNT_W'(cfg_wr_setup)  : CNT_W'(cfg_rd_setup);
  assign strobe_len = sel_wr ? CNT_W'(cfg_wr_strobe) : CNT_W'(cfg_rd_strobe);
  assign hold_len   = sel_wr ? CNT_W'(cfg_wr_hold)   : CNT_W'(cfg_rd_hold);
  assign turn_len   = CNT_W'(cfg_turn);

  xbus_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .setup_len   (setup_len),
    .strobe_len  (strobe_len),
    .hold_len    (hold_len),
    .turn_len    (turn_len),
    .stall       (stall),
    .phase       (phase),
    .strobe_last (strobe_last),
    .strobe_end  (strobe_end),
    .hold_last   (hold_last),
    .idle        (idle)
  );

  xbus_wait_unit #(.WCNT_W(WCNT_W)) u_wait (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_last (strobe_last),
    .wait_en     (cfg_wait_en),
    .wait_pol    (cfg_wait_pol),
    .wait_in     (bus_wait),
    .wait_max    (cfg_wait_max),
    .stall       (stall),
    .expire      (expire)
  );

  xbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .strobe_end (strobe_end),
    .expire     (expire),
    .bus_din    (bus_din),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .rdata      (rsp_rdata),
    .acc_err    (acc_err),
    .tmo_sticky (tmo_flag)
  );

  assign in_window = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign in_strobe = (phase == PH_STROBE);

  assign req_ready = idle;
  assign rsp_valid = hold_last;
  assign rsp_err   = acc_err;
  assign bus_cs_n  = !in_window;
  assign bus_oe_n  = !(in_strobe && !acc_wr);
  assign bus_we_n  = !(in_strobe && acc_wr);
  assign bus_addr  = acc_addr;
  assign bus_dout  = acc_wdata;
  assign bus_dq_oe = in_window && acc_wr;

  // R10: read and write strobes are mutually exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!bus_oe_n, !bus_we_n}));

  // R10: a strobe only appears inside the chip-select window
  p_strobe_in_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |-> !bus_cs_n);

  // R9: address is held for the whole window
  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

  // R9: an accepted request opens the window on the next cycle
  p_accept_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!bus_cs_n && !req_ready));

  // R4: the response pulse lasts one cycle
  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3: the data bus is only driven inside the window
  p_drive_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dq_oe |-> !bus_cs_n);

endmodule

// File: tb/tb_xbus_async_master.sv
module tb_xbus_async_master;
  import xbus_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [3:0]  cfg_rd_setup = 0, cfg_wr_setup = 0;
  logic [5:0]  cfg_rd_strobe = 0, cfg_wr_strobe = 0;
  logic [2:0]  cfg_rd_hold = 0, cfg_wr_hold = 0;
  logic [1:0]  cfg_turn = 0;
  logic        cfg_wait_en = 0, cfg_wait_pol = 1;
  logic [7:0]  cfg_wait_max = 0;
  logic        req_valid = 0, req_write = 0;
  logic [19:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic        req_ready, rsp_valid, rsp_err, tmo_flag;
  logic [15:0] rsp_rdata, bus_dout, bus_din;
  logic        bus_cs_n, bus_oe_n, bus_we_n, bus_dq_oe, bus_wait;
  logic [19:0] bus_addr;

  xbus_async_master dut (.*);

  // ---------------- external memory model ----------------
  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];
  int          wait_len = 0;
  int          stb_idx = 0;
  logic        wait_raw;

  initial for (int i = 0; i < 256; i++) begin
    mem[i]     = 16'(i * 257) ^ 16'hA5C3;
    exp_mem[i] = 16'(i * 257) ^ 16'hA5C3;
  end

  always_comb bus_din = !bus_oe_n ? mem[bus_addr[7:0]] : 16'hFFFF;
  assign wait_raw = (!bus_oe_n || !bus_we_n) && (stb_idx < wait_len);
  assign bus_wait = cfg_wait_pol ? wait_raw : !wait_raw;

  always @(posedge clk) begin
    if (!bus_oe_n || !bus_we_n) stb_idx <= stb_idx + 1;
    else                        stb_idx <= 0;
    if (!bus_we_n && bus_dq_oe) mem[bus_addr[7:0]] <= bus_dout;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          wr;
    logic [15:0] data;
    int          cs;
    int          stb;
    bit          err;
    bit          gap_chk;
    int          gap;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d,
                       input bit gap_chk, input string tag);
    item_t it;
    int su, st, ho, ext;
    su  = wr ? int'(cfg_wr_setup)  : int'(cfg_rd_setup);
    st  = wr ? int'(cfg_wr_strobe) : int'(cfg_rd_strobe);
    ho  = wr ? int'(cfg_wr_hold)   : int'(cfg_rd_hold);
    ext = 0;
    it.err = 0;
    if (cfg_wait_en && wait_len > st) begin
      ext = wait_len - st;
      if (ext > int'(cfg_wait_max)) begin
        ext    = int'(cfg_wait_max);
        it.err = 1;
      end
    end
    it.wr      = wr;
    it.cs      = int'(window_cycles(su, st, ho, ext));
    it.stb     = st + 1 + ext;
    it.gap_chk = gap_chk;
    it.gap     = int'(cfg_turn) + 2;
    it.tag     = tag;
    if (wr) begin
      it.data = d;
      exp_mem[a[7:0]] = d;
    end else begin
      it.data = exp_mem[a[7:0]];
    end
    q.push_back(it);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    repeat (8) @(negedge clk);
  endtask

  // monitor
  int cs_cnt = 0, oe_cnt = 0, we_cnt = 0, dq_cnt = 0, hi_cnt = 0, last_gap = 0;
  bit dout_ok = 1;
  logic [15:0] cur_wdata = 0;
  always @(negedge clk) if (rst_n) begin
    if (!bus_cs_n) begin
      if (cs_cnt == 0) begin
        last_gap = hi_cnt;
        dout_ok  = 1;
        if (q.size() > 0) cur_wdata = q[0].data;
      end
      hi_cnt = 0;
      cs_cnt++;
      if (q.size() > 0 && q[0].wr && bus_dout != cur_wdata) dout_ok = 0;
    end else hi_cnt++;
    if (!bus_oe_n) oe_cnt++;
    if (!bus_we_n) we_cnt++;
    if (bus_dq_oe) dq_cnt++;
    if (rsp_valid) begin
      if (q.size() == 0) chk(0, "R4 unexpected response", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(cs_cnt == it.cs, {it.tag, " R2/R3 cs window"}, cs_cnt, it.cs);
        chk(rsp_err == it.err, {it.tag, " R8 rsp_err"}, rsp_err, it.err);
        if (it.wr) begin
          chk(we_cnt == it.stb && oe_cnt == 0, {it.tag, " R3 we strobe"}, we_cnt, it.stb);
          chk(dq_cnt == it.cs && dout_ok, {it.tag, " R3 data drive"}, dq_cnt, it.cs);
        end else begin
          chk(oe_cnt == it.stb && we_cnt == 0, {it.tag, " R2 oe strobe"}, oe_cnt, it.stb);
          chk(dq_cnt == 0, {it.tag, " R2 no drive on read"}, dq_cnt, 0);
          chk(rsp_rdata == it.data, {it.tag, " R4 read data"}, rsp_rdata, it.data);
        end
        if (it.gap_chk)
          chk(last_gap == it.gap, {it.tag, " R5 turnaround gap"}, last_gap, it.gap);
      end
      cs_cnt = 0; oe_cnt = 0; we_cnt = 0; dq_cnt = 0;
    end
  end

  // R9: ready stays low during the whole access and turnaround
  int busy_ready = 0;
  always @(negedge clk) if (rst_n && !bus_cs_n && req_ready) busy_ready++;

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_cs_n && bus_oe_n && bus_we_n && !bus_dq_oe, "R1 bus idle in reset", 0, 1);
    chk(req_ready && !rsp_valid && !tmo_flag, "R1 handshake idle in reset", 0, 1);
    rst_n = 1;
    @(negedge clk);

    // R2 / R4 reads with small fields
    cfg_rd_setup = 1; cfg_rd_strobe = 2; cfg_rd_hold = 0; cfg_turn = 1;
    issue(0, 20'h00010, 0, 0, "rd1");
    issue(0, 20'h000FE, 0, 1, "rd2");
    drain();

    // R3 writes, then read back
    cfg_wr_setup = 0; cfg_wr_strobe = 3; cfg_wr_hold = 2;
    issue(1, 20'h00021, 16'h1234, 0, "wr1");
    issue(1, 20'h00022, 16'hBEEF, 1, "wr2");
    issue(0, 20'h00021, 0, 1, "rb1");
    issue(0, 20'h00022, 0, 1, "rb2");
    drain();

    // R5 turnaround extremes
    cfg_turn = 0;
    issue(0, 20'h00001, 0, 0, "t0a");
    issue(1, 20'h00002, 16'h0F0F, 1, "t0b");
    drain();
    cfg_turn = 3;
    issue(1, 20'h00003, 16'h7777, 0, "t3a");
    issue(0, 20'h00003, 0, 1, "t3b");
    drain();

    // R6 wait, active high then active low
    cfg_wait_en = 1; cfg_wait_pol = 1; cfg_wait_max = 10; wait_len = 5;
    issue(0, 20'h00040, 0, 0, "wait_hi_rd");
    issue(1, 20'h00041, 16'hCAFE, 1, "wait_hi_wr");
    drain();
    cfg_wait_pol = 0; wait_len = 7;
    issue(0, 20'h00041, 0, 0, "wait_lo_rd");
    drain();
    chk(!tmo_flag, "R8 no timeout within bound", tmo_flag, 0);

    // R8 bound exactly reached but not exceeded: L = strobe + max
    cfg_wait_pol = 1; cfg_wait_max = 2; wait_len = 2 + 2;
    issue(0, 20'h00042, 0, 0, "wait_at_bound");
    drain();
    chk(!tmo_flag, "R8 at bound no flag", tmo_flag, 0);

    // R7 wait disabled: ignored
    cfg_wait_en = 0; wait_len = 40;
    issue(0, 20'h00043, 0, 0, "wait_off_rd");
    issue(1, 20'h00044, 16'h5A5A, 1, "wait_off_wr");
    drain();

    // R8 timeout, then sticky with clean next access
    cfg_wait_en = 1; cfg_wait_pol = 0; cfg_wait_max = 2; wait_len = 30;
    issue(0, 20'h00045, 0, 0, "tmo_rd");
    drain();
    chk(tmo_flag, "R8 sticky set", tmo_flag, 1);
    wait_len = 0;
    issue(0, 20'h00046, 0, 0, "after_tmo");
    drain();
    chk(tmo_flag, "R8 sticky held", tmo_flag, 1);

    // R2 maximum field values
    cfg_wait_en = 0; cfg_rd_setup = 15; cfg_rd_strobe = 63; cfg_rd_hold = 7;
    issue(0, 20'h000FF, 0, 0, "rd_max");
    drain();

    chk(busy_ready == 0, "R9 ready low while busy", busy_ready, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule